// File: doc/BRIEF.md
# Fractional-Rate Nanosecond Time Counter

This block keeps a 64-bit nanosecond time value for a precision time protocol clock. On every timer clock cycle in which it runs, it adds an integer number of nanoseconds plus the carry out of a 32-bit fractional accumulator. The fractional part lets software trim the clock rate in very small steps. The nominal step for a reference frequency f is 1e9 · 2^32 / f in 32.32 fixed point. For example, a 333.333 MHz reference gives a step just above 3 ns.

The raw count is never rewritten to adjust time. Software steers time through a separate signed 64-bit offset instead. The reported time is the count plus that offset, and it is driven on a registered output that feeds the alarm and capture logic. Both 64-bit registers are written through a low-half shadow, and neither changes until its high half is written. A read of the low half of the current time captures the high half, so a 64-bit time read in two accesses is never torn.

Top module: `tod_ns_counter`

## Requirements
- R1: After reset, `time_now` is 0, and reads of the control, addend and now-low registers all return 0.
- R2: The register map is as follows:
  - address 0: control
  - address 1: fractional addend
  - addresses 2 and 3: count low and count high
  - addresses 4 and 5: offset low and offset high
  - addresses 6 and 7: now low and now high
- R3: The control register fields are as follows:
  - bit 0: run
  - bits 2:1: source select, where 3 means no source
  - bit 3: commit mode
  - bits 13:4: integer period
  
  A read returns the last written control value. Every read returns its data one cycle after `rd_en`.
- R4: The count changes only in a cycle in which run is 1 and source select is not 3. Otherwise it holds its value.
- R5: Each running cycle adds the active integer period plus the carry out of a 32-bit accumulator that adds the fractional addend. An addend of 0x8000_0000 therefore adds exactly one extra nanosecond every two cycles.
- R6: A control write with commit mode 0 makes its integer period active from the next cycle.
- R7: A control write with commit mode 1 leaves the active integer period unchanged. The new period becomes active only when the addend register is next written.
- R8: A count-low write only fills a shadow. A count-high write loads {high data, shadow} into the count. A count-low write alone leaves the time unchanged.
- R9: The offset uses the same low-shadow, high-commit rule. Its halves read back at addresses 4 and 5.
- R10: `time_now` equals count plus offset modulo 2^64, so a negative offset in two's complement moves time backward.
- R11: A now-low read returns the low 32 bits of the current time and captures the high 32 bits. A now-high read returns that capture, which holds until the next now-low read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Registered read data, valid one cycle after `rd_en` |
| time_now | output | 64 | Current time, count plus offset |

## Verification
The bench measures the time advance over fixed windows of cycles, so it can detect three faults:
- a dropped fractional carry, which gives 20 instead of 25 over ten half-addend cycles;
- a period that ignores commit mode and changes before the addend write;
- a counter that keeps running with source 3 selected.

It writes only the low half of the count and expects no change, which catches a design that loads the low half directly. It rewrites the count between a now-low and a now-high read, which catches a design whose high half reads live instead of from the capture. A negative offset checks that the offset is added as two's complement and wraps, not added as an unsigned value.

// File: rtl/tod_pkg.sv
package tod_pkg;
  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_ADDEND = 3'd1,
    REG_CNT_LO = 3'd2,
    REG_CNT_HI = 3'd3,
    REG_OFF_LO = 3'd4,
    REG_OFF_HI = 3'd5,
    REG_NOW_LO = 3'd6,
    REG_NOW_HI = 3'd7
  } tod_reg_e;

  localparam int CTRL_RUN     = 0;
  localparam int CTRL_SRC_LSB = 1;
  localparam int CTRL_COMMIT  = 3;
  localparam int CTRL_PER_LSB = 4;
  localparam logic [1:0] SRC_NONE = 2'b11;
endpackage

// File: rtl/tod_rate_unit.sv
module tod_rate_unit #(
  parameter int INT_W  = 10,
  parameter int FRAC_W = 32,
  parameter int FULL_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic              defer,
  input  logic [INT_W-1:0]  per_val,
  input  logic              addend_we,
  input  logic [FRAC_W-1:0] addend,
  input  logic              tick,
  output logic [FULL_W-1:0] step,
  output logic [FRAC_W-1:0] frac_q
);
  logic [INT_W-1:0]  int_act, int_pend;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   acc_sum;

  assign acc_sum = {1'b0, acc_q} + {1'b0, frac_q};
  assign step    = FULL_W'(int_act) + FULL_W'(acc_sum[FRAC_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      int_act  <= '0;
      int_pend <= '0;
      frac_q   <= '0;
      acc_q    <= '0;
    end else begin
      if (ctrl_we) begin
        int_pend <= per_val;
        if (!defer) int_act <= per_val;
      end
      if (addend_we) begin
        frac_q  <= addend;
        int_act <= int_pend;
      end
      if (tick) acc_q <= acc_sum[FRAC_W-1:0];
    end
  end

  // R7: a deferred period write leaves the active period alone
  a_r7_defer_hold: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && defer && !addend_we) |=> $stable(int_act));

  // R7: an addend write commits the pending period
  a_r7_commit: assert property (@(posedge clk) disable iff (rst)
    addend_we |=> (int_act == $past(int_pend)));

  // R6: an immediate period write takes effect next cycle
  a_r6_direct: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && !defer) |=> (int_act == $past(per_val)));
endmodule

// File: rtl/tod_wide_reg.sv
module tod_wide_reg #(
  parameter int HALF_W = 32,
  parameter bit GROWS  = 1'b0,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              adv,
  input  logic [FULL_W-1:0] step,
  output logic [FULL_W-1:0] value,
  output logic [FULL_W-1:0] value_d
);
  logic [HALF_W-1:0] lo_sh;
  logic [FULL_W-1:0] idle_d;

  generate
    if (GROWS) begin : g_count
      assign idle_d = adv ? value + step : value;
    end else begin : g_hold
      logic unused_hold;
      assign unused_hold = ^{adv, step};
      assign idle_d = value;
    end
  endgenerate

  assign value_d = wr_hi ? {wr_data, lo_sh} : idle_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_sh <= '0;
      value <= '0;
    end else begin
      if (wr_lo) lo_sh <= wr_data;
      value <= value_d;
    end
  end

  // R8/R9: high write loads high data over the low shadow
  a_r8_load: assert property (@(posedge clk) disable iff (rst)
    wr_hi |=> (value == {$past(wr_data), $past(lo_sh)}));

  // R4: no advance and no load means the value holds
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_hi && !(GROWS && adv)) |=> $stable(value));

  // R5: a running cycle adds the step
  a_r5_step: assert property (@(posedge clk) disable iff (rst)
    (GROWS && adv && !wr_hi) |=> (value == $past(value) + $past(step)));
endmodule

// File: rtl/tod_ns_counter.sv
module tod_ns_counter #(
  parameter int HALF_W = 32,
  parameter int INT_W  = 10,
  localparam int FULL_W = 2 * HALF_W,
  localparam int CTRL_W = tod_pkg::CTRL_PER_LSB + INT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [2:0]        rd_addr,
  output logic [HALF_W-1:0] rd_data,
  output logic [FULL_W-1:0] time_now
);
  import tod_pkg::*;

  logic [CTRL_W-1:0] ctrl_q;
  logic [HALF_W-1:0] snap_hi, frac_q;
  logic [FULL_W-1:0] cnt_q, cnt_d, off_q, off_d, step;
  logic wr_ctrl, wr_add, tick;

  assign wr_ctrl = wr_en && (wr_addr == REG_CTRL);
  assign wr_add  = wr_en && (wr_addr == REG_ADDEND);
  assign tick    = ctrl_q[CTRL_RUN] &&
                   (ctrl_q[CTRL_SRC_LSB +: 2] != SRC_NONE);

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wr_data[CTRL_W-1:0];
  end

  tod_rate_unit #(.INT_W(INT_W), .FRAC_W(HALF_W), .FULL_W(FULL_W)) u_rate (
    .clk(clk), .rst(rst),
    .ctrl_we(wr_ctrl), .defer(wr_data[CTRL_COMMIT]),
    .per_val(wr_data[CTRL_PER_LSB +: INT_W]),
    .addend_we(wr_add), .addend(wr_data),
    .tick(tick), .step(step), .frac_q(frac_q)
  );

  tod_wide_reg #(.HALF_W(HALF_W), .GROWS(1'b1)) u_count (
    .clk(clk), .rst(rst),
    .wr_lo(wr_en && (wr_addr == REG_CNT_LO)),
    .wr_hi(wr_en && (wr_addr == REG_CNT_HI)),
    .wr_data(wr_data), .adv(tick), .step(step),
    .value(cnt_q), .value_d(cnt_d)
  );

  tod_wide_reg #(.HALF_W(HALF_W), .GROWS(1'b0)) u_offset (
    .clk(clk), .rst(rst),
    .wr_lo(wr_en && (wr_addr == REG_OFF_LO)),
    .wr_hi(wr_en && (wr_addr == REG_OFF_HI)),
    .wr_data(wr_data), .adv(1'b0), .step('0),
    .value(off_q), .value_d(off_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      time_now <= '0;
      snap_hi  <= '0;
      rd_data  <= '0;
    end else begin
      time_now <= cnt_d + off_d;
      if (rd_en) begin
        case (tod_reg_e'(rd_addr))
          REG_CTRL:   rd_data <= HALF_W'(ctrl_q);
          REG_ADDEND: rd_data <= frac_q;
          REG_CNT_LO: rd_data <= cnt_q[HALF_W-1:0];
          REG_CNT_HI: rd_data <= cnt_q[FULL_W-1:HALF_W];
          REG_OFF_LO: rd_data <= off_q[HALF_W-1:0];
          REG_OFF_HI: rd_data <= off_q[FULL_W-1:HALF_W];
          REG_NOW_LO: begin
            rd_data <= time_now[HALF_W-1:0];
            snap_hi <= time_now[FULL_W-1:HALF_W];
          end
          default:    rd_data <= snap_hi;
        endcase
      end
    end
  end

  // R11: a now-low read returns one coherent 64-bit time
  a_r11_snap: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == REG_NOW_LO) |=> ({snap_hi, rd_data} == $past(time_now)));

  // R10: reported time tracks count plus offset
  a_r10_sum: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (time_now == $past(cnt_d) + $past(off_d)));
endmodule

// File: tb/sim_tod_ns_counter.sv
module sim_tod_ns_counter;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [63:0] time_now;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  tod_ns_counter u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .time_now(time_now));

  function automatic logic [31:0] cw(input bit run, input logic [1:0] src,
                                     input bit commit, input logic [9:0] per);
    return {18'd0, per, commit, src, run};
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic advance(input int k, output logic [63:0] diff);
    logic [63:0] t0;
    @(negedge clk); t0 = time_now;
    repeat (k) @(negedge clk);
    diff = time_now - t0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 time", time_now, 64'd0);
    rd(3'd0, d); chk("R1 ctrl", {32'd0, d}, 64'd0);
    rd(3'd1, d); chk("R1 addend", {32'd0, d}, 64'd0);
    rd(3'd6, d); chk("R1 now_lo", {32'd0, d}, 64'd0);
  endtask

  task automatic t_integer();
    logic [63:0] df; logic [31:0] d;
    wr(3'd0, cw(1, 2'd1, 0, 10'd3)); wr(3'd1, 32'd0);
    advance(4, df); chk("R6 int period 3", df, 64'd12);
    rd(3'd0, d); chk("R3 ctrl readback", {32'd0, d}, {32'd0, cw(1, 2'd1, 0, 10'd3)});
    wr(3'd0, cw(1, 2'd2, 0, 10'd7));
    advance(3, df); chk("R6 immediate period 7", df, 64'd21);
  endtask

  task automatic t_commit();
    logic [63:0] df;
    wr(3'd0, cw(1, 2'd0, 0, 10'd3)); wr(3'd1, 32'd0);
    wr(3'd0, cw(1, 2'd0, 1, 10'd5));
    advance(4, df); chk("R7 deferred keeps 3", df, 64'd12);
    wr(3'd1, 32'd0);
    advance(4, df); chk("R7 committed 5", df, 64'd20);
  endtask

  task automatic t_fraction();
    logic [63:0] df; logic [31:0] d;
    wr(3'd0, cw(1, 2'd1, 0, 10'd2)); wr(3'd1, 32'h8000_0000);
    advance(10, df); chk("R5 half carry", df, 64'd25);
    rd(3'd1, d); chk("R2 addend readback", {32'd0, d}, 64'h8000_0000);
  endtask

  task automatic t_stall();
    logic [63:0] df;
    wr(3'd0, cw(0, 2'd1, 0, 10'd7));
    advance(5, df); chk("R4 run off", df, 64'd0);
    wr(3'd0, cw(1, 2'd3, 0, 10'd7));
    advance(5, df); chk("R4 source none", df, 64'd0);
  endtask

  task automatic t_load_snap();
    logic [31:0] d; logic [63:0] t;
    wr(3'd0, cw(0, 2'd1, 0, 10'd3));
    wr(3'd2, 32'h0000_0010); wr(3'd3, 32'h0000_0005);
    @(negedge clk); chk("R8 count load", time_now, 64'h0000_0005_0000_0010);
    t = time_now;
    wr(3'd2, 32'h0000_1234);
    @(negedge clk); chk("R8 low only no change", time_now, t);
    rd(3'd6, d); chk("R11 now_lo", {32'd0, d}, 64'h10);
    wr(3'd2, 32'd0); wr(3'd3, 32'd9);
    rd(3'd7, d); chk("R11 now_hi held", {32'd0, d}, 64'd5);
    rd(3'd3, d); chk("R2 count high live", {32'd0, d}, 64'd9);
    rd(3'd6, d); rd(3'd7, d); chk("R11 new capture", {32'd0, d}, 64'd9);
  endtask

  task automatic t_offset();
    logic [31:0] d;
    wr(3'd4, 32'hFFFF_FF9C);
    @(negedge clk); chk("R9 offset low shadow only", time_now, 64'h0000_0009_0000_0000);
    wr(3'd5, 32'hFFFF_FFFF);
    @(negedge clk); chk("R10 negative offset", time_now, 64'h0000_0008_FFFF_FF9C);
    rd(3'd4, d); chk("R9 offset lo read", {32'd0, d}, 64'hFFFF_FF9C);
    rd(3'd5, d); chk("R9 offset hi read", {32'd0, d}, 64'hFFFF_FFFF);
    wr(3'd4, 32'd0); wr(3'd5, 32'd0);
    wr(3'd2, 32'hFFFF_FFFE); wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd4, 32'd5); wr(3'd5, 32'd0);
    @(negedge clk); chk("R10 wrap", time_now, 64'd3);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_integer();
    t_commit();
    t_fraction();
    t_stall();
    t_load_snap();
    t_offset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule